// File: doc/BRIEF.md
# FPGA SPI-Slave Configuration Sequencer

This block loads a configuration image into an FPGA that accepts its image as an SPI slave. It drives the target's active-low reset, chip select, serial clock and serial data line, and it also holds the hold and write-protect pins of a shared SPI flash low for the whole run, so the flash stays off the bus. Configuration bytes arrive on a valid/ready stream, and a last flag marks the final byte.

One start pulse runs the whole handshake. The block first parks the flash and waits a guard time. It then pulls chip select and reset low together, releases reset while chip select stays low, and sends a fixed number of dummy clocks followed by a settling wait. Next it shifts out the image most-significant bit first. After the last byte it raises chip select and keeps clocking until the done input rises or a timeout passes. Once done is seen it sends a run of release clocks. The run ends with a one-cycle success or failure pulse.

Every delay and every clock phase is a parameter counted in system clock cycles. This lets a system use real millisecond values and a simulation use short ones.

Top module: `fpga_cfg_seq`

## Requirements
- R1: Out of reset and whenever busy is low: chip select, serial clock, data, target reset, flash hold and flash write-protect are all high; busy, ready, success and failure are low.
- R2: After an accepted start, flash hold and write-protect go low and stay low until the run ends. They are low for exactly GUARD_CYC cycles before chip select falls.
- R3: Chip select and target reset fall in the same cycle. Reset stays low for exactly RESET_CYC cycles and then rises while chip select stays low.
- R4: After reset rises, exactly DUMMY_NUM clock pulses are issued before the first data bit. Each pulse is low for DUMMY_HALF cycles and then high for DUMMY_HALF cycles.
- R5: Each byte is shifted out most-significant bit first. A new data bit is set when the clock falls, and it is held stable through the rising edge at which the target samples it.
- R6: Ready is high only while the block waits for a byte. While it waits, the clock stays high and chip select stays low, so any gap in the stream just lengthens the high phase.
- R7: The byte that carries the last flag ends the data phase. Chip select rises right after its eighth bit, and the total number of clock pulses with chip select low is DUMMY_NUM plus 8 per byte.
- R8: With chip select high, poll pulses are repeated back to back. The done input is sampled in the final cycle of each poll pulse, and the first pulse that finds done high ends polling.
- R9: Polling starts at elapsed count 0 and the count advances one per cycle. If, at the end of a poll pulse, done is low and the elapsed count is at least TIMEOUT_CYC, the block stops clocking, issues no release pulses and pulses failure. With back-to-back pulses of half period H, this happens after ceil((TIMEOUT_CYC+1)/(2H)) poll pulses.
- R10: When done is found high on the same poll pulse that would otherwise trigger the timeout, the run succeeds.
- R11: After done is seen, exactly REL_NUM release pulses are issued, each low for REL_HALF cycles and high for REL_HALF cycles. Success is then pulsed and the flash pins return high.
- R12: Busy rises the cycle after an accepted start. Success and failure are single-cycle pulses and appear in the first cycle with busy low. A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| s_data_i | input | 8 | Configuration byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Marks the final byte |
| s_ready_o | output | 1 | Byte accepted when high with valid |
| cfg_rst_n_o | output | 1 | Target reset, active low |
| cfg_cs_n_o | output | 1 | Target chip select, active low |
| cfg_sck_o | output | 1 | Serial clock, idles high |
| cfg_mosi_o | output | 1 | Serial data to target |
| flash_hold_n_o | output | 1 | Flash hold, driven low while busy |
| flash_wp_n_o | output | 1 | Flash write-protect, driven low while busy |
| done_i | input | 1 | Target configuration done |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
Two decisions can fall on the same cycle: the end-of-pulse sample of done and the timeout decision. Both are taken in the last cycle of a poll pulse. The bench computes from the parameters which poll pulse first reaches the timeout. In one run it raises done right after that pulse's rising edge, and it expects success followed by the full set of release pulses. In a second run it never raises done, and it expects failure after exactly that many poll pulses with no release clocks.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_GUARD,
        SQ_RESET,
        SQ_DUMMY,
        SQ_SETTLE,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_POLL,
        SQ_RELEASE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } pulse_phase_e;

endpackage

// File: rtl/fpga_cfg_delay.sv
// One-shot delay counter: go_i loads a length, end_o marks the last counted cycle.
module fpga_cfg_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [DW-1:0] len_i,
    output logic          end_o
);
    typedef struct packed {
        logic          active;
        logic [DW-1:0] cnt;
    } dly_t;

    dly_t q, d;

    always_comb begin
        d = q;
        if (q.active) begin
            if (q.cnt == '0) d.active = 1'b0;
            else             d.cnt    = q.cnt - 1'b1;
        end
        if (go_i) begin
            d.active = 1'b1;
            d.cnt    = len_i - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign end_o = q.active && (q.cnt == '0);

    // A new delay may only be requested when the counter is free (R2, R3).
    assert_dly_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (!q.active || end_o));
endmodule

// File: rtl/fpga_cfg_pulse.sv
// Single clock-pulse generator: low for half_i cycles, then high for half_i cycles.
module fpga_cfg_pulse #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [HW-1:0] half_i,
    output logic          sck_o,
    output logic          end_o
);
    import fpga_cfg_pkg::*;

    typedef struct packed {
        pulse_phase_e  ph;
        logic [HW-1:0] cnt;
        logic [HW-1:0] half;
        logic          sck;
    } pls_t;

    pls_t q, d;

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_HIGH;
                    d.cnt = q.half - 1'b1;
                    d.sck = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (q.cnt == '0) d.ph  = PH_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: ;
        endcase
        if (go_i) begin
            d.ph   = PH_LOW;
            d.cnt  = half_i - 1'b1;
            d.half = half_i;
            d.sck  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, cnt: '0, half: '0, sck: 1'b1};
        else        q <= d;
    end

    assign sck_o = q.sck;
    assign end_o = (q.ph == PH_HIGH) && (q.cnt == '0);

    // A pulse is requested only when the previous one is finished (R8).
    assert_pulse_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> ((q.ph == PH_IDLE) || end_o));
    // The clock leaves the low phase only after the programmed count (R4).
    assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_LOW && q.cnt != '0 && !go_i) |=> !q.sck);
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq #(
    parameter int GUARD_CYC   = 100000,
    parameter int RESET_CYC   = 1000000,
    parameter int DUMMY_HALF  = 10000,
    parameter int DUMMY_NUM   = 8,
    parameter int SETTLE_CYC  = 1000000,
    parameter int DATA_HALF   = 4,
    parameter int TIMEOUT_CYC = 200000000,
    parameter int REL_HALF    = 20000,
    parameter int REL_NUM     = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       cfg_rst_n_o,
    output logic       cfg_cs_n_o,
    output logic       cfg_sck_o,
    output logic       cfg_mosi_o,
    output logic       flash_hold_n_o,
    output logic       flash_wp_n_o,
    input  logic       done_i,
    output logic       busy_o,
    output logic       ok_o,
    output logic       fail_o
);
    import fpga_cfg_pkg::*;

    localparam int DLY_A   = (GUARD_CYC > RESET_CYC) ? GUARD_CYC : RESET_CYC;
    localparam int DLY_MAX = (DLY_A > SETTLE_CYC) ? DLY_A : SETTLE_CYC;
    localparam int HLF_A   = (DUMMY_HALF > DATA_HALF) ? DUMMY_HALF : DATA_HALF;
    localparam int HLF_MAX = (HLF_A > REL_HALF) ? HLF_A : REL_HALF;
    localparam int NUM_MAX = (DUMMY_NUM > REL_NUM) ? DUMMY_NUM : REL_NUM;
    localparam int DW = $clog2(DLY_MAX + 1);
    localparam int HW = $clog2(HLF_MAX + 1);
    localparam int NW = $clog2(NUM_MAX + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1) + 1;

    typedef struct packed {
        seq_state_e    state;
        logic          cs_n;
        logic          trst_n;
        logic          hold_n;
        logic          mosi;
        logic [7:0]    sh;
        logic [2:0]    bitn;
        logic [NW-1:0] pcnt;
        logic          last;
        logic [TW-1:0] tmo;
        logic          ok;
        logic          fail;
    } seq_t;

    seq_t q, d;

    logic          dly_go, dly_end;
    logic [DW-1:0] dly_len;
    logic          p_go, p_end, sck;
    logic [HW-1:0] p_half;

    fpga_cfg_delay #(.DW(DW)) u_delay (
        .clk(clk), .rst_n(rst_n), .go_i(dly_go), .len_i(dly_len), .end_o(dly_end)
    );

    fpga_cfg_pulse #(.HW(HW)) u_pulse (
        .clk(clk), .rst_n(rst_n), .go_i(p_go), .half_i(p_half),
        .sck_o(sck), .end_o(p_end)
    );

    always_comb begin
        d       = q;
        d.ok    = 1'b0;
        d.fail  = 1'b0;
        dly_go  = 1'b0;
        dly_len = '0;
        p_go    = 1'b0;
        p_half  = '0;
        unique case (q.state)
            SQ_IDLE: if (start_i) begin
                d.state = SQ_GUARD;
                d.hold_n = 1'b0;
                dly_go = 1'b1;
                dly_len = DW'(GUARD_CYC);
            end
            SQ_GUARD: if (dly_end) begin
                d.state = SQ_RESET;
                d.cs_n = 1'b0;
                d.trst_n = 1'b0;
                dly_go = 1'b1;
                dly_len = DW'(RESET_CYC);
            end
            SQ_RESET: if (dly_end) begin
                d.state = SQ_DUMMY;
                d.trst_n = 1'b1;
                d.pcnt = '0;
                p_go = 1'b1;
                p_half = HW'(DUMMY_HALF);
            end
            SQ_DUMMY: if (p_end) begin
                if (q.pcnt == NW'(DUMMY_NUM - 1)) begin
                    d.state = SQ_SETTLE;
                    dly_go = 1'b1;
                    dly_len = DW'(SETTLE_CYC);
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                    p_go = 1'b1;
                    p_half = HW'(DUMMY_HALF);
                end
            end
            SQ_SETTLE: if (dly_end) d.state = SQ_LOAD;
            SQ_LOAD: if (s_valid_i) begin
                d.state = SQ_SHIFT;
                d.sh = s_data_i;
                d.mosi = s_data_i[7];
                d.bitn = '0;
                d.last = s_last_i;
                p_go = 1'b1;
                p_half = HW'(DATA_HALF);
            end
            SQ_SHIFT: if (p_end) begin
                if (q.bitn == 3'd7) begin
                    if (q.last) begin
                        d.state = SQ_POLL;
                        d.cs_n = 1'b1;
                        d.mosi = 1'b1;
                        d.tmo = '0;
                        p_go = 1'b1;
                        p_half = HW'(DUMMY_HALF);
                    end else begin
                        d.state = SQ_LOAD;
                    end
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.sh = {q.sh[6:0], 1'b0};
                    d.mosi = q.sh[6];
                    p_go = 1'b1;
                    p_half = HW'(DATA_HALF);
                end
            end
            SQ_POLL: begin
                d.tmo = q.tmo + 1'b1;
                if (p_end) begin
                    if (done_i) begin
                        d.state = SQ_RELEASE;
                        d.pcnt = '0;
                        p_go = 1'b1;
                        p_half = HW'(REL_HALF);
                    end else if (q.tmo >= TW'(TIMEOUT_CYC)) begin
                        d.state = SQ_IDLE;
                        d.hold_n = 1'b1;
                        d.fail = 1'b1;
                    end else begin
                        p_go = 1'b1;
                        p_half = HW'(DUMMY_HALF);
                    end
                end
            end
            SQ_RELEASE: if (p_end) begin
                if (q.pcnt == NW'(REL_NUM - 1)) begin
                    d.state = SQ_IDLE;
                    d.hold_n = 1'b1;
                    d.ok = 1'b1;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                    p_go = 1'b1;
                    p_half = HW'(REL_HALF);
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= SQ_IDLE;
            q.cs_n   <= 1'b1;
            q.trst_n <= 1'b1;
            q.hold_n <= 1'b1;
            q.mosi   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign s_ready_o      = (q.state == SQ_LOAD);
    assign cfg_rst_n_o    = q.trst_n;
    assign cfg_cs_n_o     = q.cs_n;
    assign cfg_sck_o      = sck;
    assign cfg_mosi_o     = q.mosi;
    assign flash_hold_n_o = q.hold_n;
    assign flash_wp_n_o   = q.hold_n;
    assign busy_o         = (q.state != SQ_IDLE);
    assign ok_o           = q.ok;
    assign fail_o         = q.fail;

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_sck_o && cfg_cs_n_o && cfg_rst_n_o && flash_hold_n_o));
    assert_flash_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cs_n_o |-> !flash_hold_n_o);
    assert_cs_with_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_rst_n_o) |-> $fell(cfg_cs_n_o));
    assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> (cfg_sck_o && !cfg_cs_n_o));
    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_sck_o) && !cfg_cs_n_o) |-> $stable(cfg_mosi_o));
    assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_o || fail_o) |-> (!busy_o && $past(busy_o) && !(ok_o && fail_o)));
endmodule

// File: tb/sim_fpga_cfg_seq.sv
module sim_fpga_cfg_seq;
    localparam int CLK_PER = 10;
    localparam int G_CYC = 4, R_CYC = 6, D_HALF = 2, D_NUM = 8, S_CYC = 5;
    localparam int B_HALF = 2, T_CYC = 60, L_HALF = 3, L_NUM = 50;
    localparam int DECIDE = (T_CYC + 1 + 2 * D_HALF - 1) / (2 * D_HALF);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] sdata = 8'h00;
    logic svalid = 1'b0, slast = 1'b0, done_tb = 1'b0;
    logic sready, trst_n, cs_n, sck, mosi, hold_n, wp_n, busy, ok, fail;

    int total = 0, bad = 0;

    fpga_cfg_seq #(
        .GUARD_CYC(G_CYC), .RESET_CYC(R_CYC), .DUMMY_HALF(D_HALF), .DUMMY_NUM(D_NUM),
        .SETTLE_CYC(S_CYC), .DATA_HALF(B_HALF), .TIMEOUT_CYC(T_CYC),
        .REL_HALF(L_HALF), .REL_NUM(L_NUM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .s_data_i(sdata),
        .s_valid_i(svalid), .s_last_i(slast), .s_ready_o(sready),
        .cfg_rst_n_o(trst_n), .cfg_cs_n_o(cs_n), .cfg_sck_o(sck), .cfg_mosi_o(mosi),
        .flash_hold_n_o(hold_n), .flash_wp_n_o(wp_n), .done_i(done_tb),
        .busy_o(busy), .ok_o(ok), .fail_o(fail)
    );

    always #(CLK_PER / 2) clk = ~clk;

    // Observation state filled by the pin monitor.
    logic cap [0:63];
    int cap_n, poll_n, rel_n, raise_at, hold_run, guard_seen, rst_run;
    int lo_run, rel_lo, ok_n, fail_n, seq_bad, hold_falls, stall_bad;
    logic same_fall;
    logic p_sck = 1'b1, p_cs = 1'b1, p_rst = 1'b1, p_busy = 1'b0, p_hold = 1'b1;

    task automatic chk(input string req, input logic cond, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        cap_n = 0; poll_n = 0; rel_n = 0; hold_run = 0; guard_seen = -1; rst_run = 0;
        lo_run = 0; rel_lo = 0; ok_n = 0; fail_n = 0; seq_bad = 0; hold_falls = 0;
        stall_bad = 0; same_fall = 1'b0; done_tb = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!hold_n && p_hold) hold_falls++;
            if (!hold_n && cs_n && !p_cs == 1'b0 && busy && guard_seen < 0) hold_run++;
            if (p_cs && !cs_n) begin
                guard_seen = hold_run;
                same_fall  = p_rst && !trst_n;
            end
            if (!trst_n) rst_run++;
            if (sready && !sck) stall_bad++;
            if (!sck) lo_run++;
            if (sck && !p_sck) begin
                if (!cs_n && trst_n) begin
                    if (cap_n < 64) cap[cap_n] = mosi;
                    cap_n++;
                end else if (cs_n && busy) begin
                    if (!done_tb) begin
                        poll_n++;
                        if (raise_at != 0 && poll_n == raise_at) done_tb = 1'b1;
                    end else begin
                        rel_n++;
                        rel_lo = lo_run;
                    end
                end
                lo_run = 0;
            end
            if (ok)   ok_n++;
            if (fail) fail_n++;
            if ((ok || fail) && !(!busy && p_busy)) seq_bad++;
        end
        p_sck = sck; p_cs = cs_n; p_rst = trst_n; p_busy = busy; p_hold = hold_n;
    end

    task automatic check_idle(input string tag);
        chk({tag, " R1 idle pins"}, cs_n && sck && mosi && trst_n && hold_n && wp_n,
            {cs_n, sck, mosi, trst_n, hold_n, wp_n}, 63);
        chk({tag, " R1 idle status"}, !busy && !sready && !ok && !fail,
            {busy, sready, ok, fail}, 0);
    endtask

    // Feeds bytes; gap cycles between bytes; optional stray start after first byte.
    task automatic run(input logic [7:0] bytes [0:3], input int n, input int gap,
                       input logic stray, input int raise, output int waited);
        clear_obs();
        raise_at = raise;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R12 busy after start", busy, busy, 1);
        for (int b = 0; b < n; b++) begin
            sdata = bytes[b]; slast = (b == n - 1); svalid = 1'b1;
            for (int w = 0; w < 2000; w++) begin
                if (sready) break;
                @(negedge clk);
            end
            @(posedge clk);
            @(negedge clk); svalid = 1'b0; slast = 1'b0;
            if (stray && b == 0) begin start = 1'b1; @(negedge clk); start = 1'b0; end
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        waited = 0;
        while (!ok && !fail && waited < 20000) begin
            @(negedge clk); waited++;
        end
        chk("R12 run finished", waited < 20000, waited, 20000);
        @(negedge clk);
    endtask

    task automatic check_bits(input string tag, input logic [7:0] bytes [0:3], input int n);
        chk({tag, " R7 pulses with cs low"}, cap_n == D_NUM + 8 * n, cap_n, D_NUM + 8 * n);
        for (int b = 0; b < n; b++) begin
            logic [7:0] got;
            for (int k = 0; k < 8; k++) got[7 - k] = cap[D_NUM + 8 * b + k];
            chk({tag, " R5 byte msb first"}, got == bytes[b], got, bytes[b]);
        end
    endtask

    task automatic t_reset();
        check_idle("reset");
    endtask

    task automatic t_basic();
        logic [7:0] by [0:3] = '{8'hA5, 8'h3C, 8'h81, 8'h00};
        int w;
        run(by, 3, 0, 1'b0, 2, w);
        chk("R2 guard length", guard_seen == G_CYC, guard_seen, G_CYC);
        chk("R3 cs and reset fall together", same_fall, same_fall, 1);
        chk("R3 reset low length", rst_run == R_CYC, rst_run, R_CYC);
        check_bits("basic", by, 3);
        chk("R8 poll pulses until done", poll_n == 2, poll_n, 2);
        chk("R11 release count", rel_n == L_NUM, rel_n, L_NUM);
        chk("R11 release low phase", rel_lo == L_HALF, rel_lo, L_HALF);
        chk("R11 success pulse", ok_n == 1 && fail_n == 0, ok_n, 1);
        chk("R12 pulse with busy falling", seq_bad == 0, seq_bad, 0);
        check_idle("basic end");
    endtask

    task automatic t_stall();
        logic [7:0] by [0:3] = '{8'h00, 8'hFF, 8'h5A, 8'h00};
        int w;
        run(by, 3, 9, 1'b1, 1, w);
        chk("R6 clock high while waiting", stall_bad == 0, stall_bad, 0);
        check_bits("stall", by, 3);
        chk("R12 stray start ignored", hold_falls == 1 && ok_n == 1, hold_falls, 1);
        chk("R11 release after stall", rel_n == L_NUM, rel_n, L_NUM);
    endtask

    task automatic t_timeout();
        logic [7:0] by [0:3] = '{8'hC3, 8'h00, 8'h00, 8'h00};
        int w;
        run(by, 1, 0, 1'b0, 0, w);
        chk("R9 failure pulse", fail_n == 1 && ok_n == 0, fail_n, 1);
        chk("R9 poll pulses at timeout", poll_n == DECIDE, poll_n, DECIDE);
        chk("R9 no release pulses", rel_n == 0, rel_n, 0);
        check_idle("timeout end");
    endtask

    task automatic t_coincide();
        logic [7:0] by [0:3] = '{8'h7E, 8'h00, 8'h00, 8'h00};
        int w;
        run(by, 1, 0, 1'b0, DECIDE, w);
        chk("R10 done wins at deciding pulse", ok_n == 1 && fail_n == 0, ok_n, 1);
        chk("R10 poll count", poll_n == DECIDE, poll_n, DECIDE);
        chk("R10 release follows", rel_n == L_NUM, rel_n, L_NUM);
        check_bits("coincide", by, 1);
    endtask

    initial begin
        clear_obs();
        raise_at = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_timeout();
        t_coincide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R12 actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule